// File: doc/BRIEF.md
# Cache Invalidation Strobe Generator

A DMA bus master that writes into host memory can leave stale copies in a host cache. This block watches every transfer the master makes while it holds the bus. It raises a one-cycle invalidation strobe whenever a write moves into a cache line that has not yet been announced, so that the host can snoop the address and drop the matching line. Two configuration inputs control it. The first is an enable bit. The second is a 5-bit line length code, counted in 4-byte units. A code of zero means the line is unbounded, and the block then announces only the first write of each ownership period.

The block also produces a mask of the address bits the master has to release while the host holds the address for a snoop. Bits above the line offset are released. The low bits that select a byte within the line stay driven. The configuration is captured when ownership begins and stays fixed until the bus is given up. Length codes that are not a power of two up to 16 are treated as unbounded lines, and they set a sticky error flag.

Top module: `cinv_strobe_gen`

## Requirements
- R1: With the enable bit captured low for an ownership period, no strobe is produced in that period.
- R2: Only write transfers presented while `bus_owned` is high can cause a strobe. Reads never strobe. Writes made while the bus is not owned never strobe.
- R3: For a legal code c in {1, 2, 4, 8, 16}, the line size is 4*c bytes. A write strobes when its first byte lies in a line other than the one in which the previous write of the period ended, or when its own bytes span two lines.
- R4: The first write after each new grant of the bus always strobes, even if it targets the line last written before the bus was released.
- R5: With code 0, exactly one strobe is produced per ownership period, on its first write.
- R6: Any nonzero code that is not a power of two up to 16 behaves like code 0. If such a code is captured with the enable high, `cfg_error` goes high and stays high until reset.
- R7: `hold_mask` bit i is 1 exactly when i >= 2 + log2(c) for a legal code c. For code 0 or a reserved code, bit i is 1 exactly when i >= 2.
- R8: The strobe is high during the cycle after the clock edge on which the triggering write is sampled. Each strobing write gives exactly one cycle of strobe.
- R9: The enable and length code are captured on the first cycle of an ownership period. Changing them later in that period changes neither the strobe pattern nor `hold_mask`.
- R10: After reset, `inv_strobe` and `cfg_error` are low and `hold_mask` releases every bit from bit 2 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables strobe generation, captured at the start of ownership |
| cfg_line_units | input | 5 | Cache line length in 4-byte units, 0 = unbounded |
| bus_owned | input | 1 | High while this master owns the bus |
| xfer_valid | input | 1 | A transfer's address phase is present this cycle |
| xfer_write | input | 1 | 1 = write transfer, 0 = read |
| xfer_addr | input | 32 | Byte address of the transfer's first byte |
| xfer_bytes | input | 3 | Bytes moved by the transfer (1 to 4, 0 treated as 1) |
| inv_strobe | output | 1 | One-cycle cache invalidation strobe |
| hold_mask | output | 32 | 1 marks an address bit released during an address hold |
| cfg_error | output | 1 | Sticky flag: a reserved length code was captured |

## Verification
If the line tracker kept a wrong last-line value, the fault would appear on the next write of the same period. That write would give a missing or an extra strobe one cycle after it is sampled. A first-access flag that failed to clear or set would show up at once as extra strobes in unbounded mode, or as a missing strobe after a new grant. If the captured configuration were wrong, both `hold_mask` and the strobe spacing would be wrong from the second cycle of the period onward. Repeated grants, line-spanning writes and reads mixed in with the writes are all used, so that each of these faults reaches `inv_strobe` within a few transfers.

// File: rtl/cinv_pkg.sv
package cinv_pkg;

    localparam int CINV_LW  = 5;
    localparam int CINV_AW  = 32;
    localparam int CINV_SW  = 3;
    localparam int CINV_SHW = $clog2(CINV_LW + 2);

    typedef enum logic [1:0] {
        LEN_LEGAL    = 2'd0,
        LEN_INFINITE = 2'd1,
        LEN_RESERVED = 2'd2
    } len_kind_e;

    typedef struct packed {
        logic                en;
        logic                inf;
        logic [CINV_SHW-1:0] shift;
    } cinv_cfg_t;

    localparam cinv_cfg_t CINV_CFG_RESET = '{en: 1'b0, inf: 1'b1, shift: CINV_SHW'(2)};

    function automatic len_kind_e classify(input logic [CINV_LW-1:0] units);
        len_kind_e k;
        if (units == '0)
            k = LEN_INFINITE;
        else if ((units & (units - CINV_LW'(1))) == '0)
            k = LEN_LEGAL;
        else
            k = LEN_RESERVED;
        return k;
    endfunction

    function automatic logic [CINV_SHW-1:0] shift_of(input logic [CINV_LW-1:0] units);
        logic [CINV_SHW-1:0] sh;
        sh = CINV_SHW'(2);
        if (classify(units) == LEN_LEGAL) begin
            for (int i = 0; i < CINV_LW; i++) begin
                if (units[i]) sh = CINV_SHW'(i + 2);
            end
        end
        return sh;
    endfunction

    function automatic cinv_cfg_t decode(input logic en, input logic [CINV_LW-1:0] units);
        cinv_cfg_t c;
        c.en    = en;
        c.inf   = (classify(units) != LEN_LEGAL);
        c.shift = shift_of(units);
        return c;
    endfunction

endpackage

// File: rtl/cinv_cfg_sampler.sv
module cinv_cfg_sampler
    import cinv_pkg::*;
#(
    parameter int LW = CINV_LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_enable,
    input  logic [LW-1:0] cfg_line_units,
    output cinv_cfg_t     eff,
    output logic          err
);

    cinv_cfg_t live;
    cinv_cfg_t held_q;
    logic      err_q;

    always_comb begin
        live = decode(cfg_enable, CINV_LW'(cfg_line_units));
        eff  = start ? live : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= CINV_CFG_RESET;
            err_q  <= 1'b0;
        end else if (start) begin
            held_q <= live;
            if (cfg_enable && classify(CINV_LW'(cfg_line_units)) == LEN_RESERVED)
                err_q <= 1'b1;
        end
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!start && !$past(rst)) |-> (eff == $past(eff))); // R9

endmodule

// File: rtl/cinv_line_tracker.sv
module cinv_line_tracker
    import cinv_pkg::*;
#(
    parameter int AW = CINV_AW,
    parameter int SW = CINV_SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          owned,
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] bytes,
    input  cinv_cfg_t     eff,
    input  logic [AW-1:0] off_mask,
    output logic          fire
);

    logic          fresh_q;
    logic [AW-1:0] last_q;
    logic [AW-1:0] span;
    logic [AW-1:0] head;
    logic [AW-1:0] tail;
    logic          beat;
    logic          new_line;

    always_comb begin
        span     = (bytes == '0) ? '0 : (AW'(bytes) - AW'(1));
        head     = addr & ~off_mask;
        tail     = (addr + span) & ~off_mask;
        beat     = owned && valid && write && eff.en;
        new_line = (head != last_q) || (tail != head);
        fire     = beat && (fresh_q || (!eff.inf && new_line));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b1;
            last_q  <= '0;
        end else if (!owned) begin
            fresh_q <= 1'b1;
        end else if (beat) begin
            fresh_q <= 1'b0;
            last_q  <= tail;
        end
    end

    AST_INF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (eff.inf && !fresh_q) |-> !fire); // R5

    AST_REGRANT_FRESH: assert property (@(posedge clk) disable iff (rst)
        !$past(owned) |-> fresh_q); // R4

endmodule

// File: rtl/cinv_hold_mask.sv
module cinv_hold_mask
    import cinv_pkg::*;
#(
    parameter int AW  = CINV_AW,
    parameter int SHW = CINV_SHW
) (
    input  logic [SHW-1:0] shift,
    output logic [AW-1:0]  mask
);

    for (genvar g = 0; g < AW; g++) begin : g_bit
        assign mask[g] = (g >= int'(shift));
    end

endmodule

// File: rtl/cinv_strobe_gen.sv
module cinv_strobe_gen
    import cinv_pkg::*;
#(
    parameter int AW = CINV_AW,
    parameter int LW = CINV_LW,
    parameter int SW = CINV_SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_enable,
    input  logic [LW-1:0] cfg_line_units,
    input  logic          bus_owned,
    input  logic          xfer_valid,
    input  logic          xfer_write,
    input  logic [AW-1:0] xfer_addr,
    input  logic [SW-1:0] xfer_bytes,
    output logic          inv_strobe,
    output logic [AW-1:0] hold_mask,
    output logic          cfg_error
);

    logic      own_q;
    logic      start;
    cinv_cfg_t eff;
    logic      fire;
    logic      strobe_q;

    assign start = bus_owned && !own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            own_q    <= bus_owned;
            strobe_q <= fire;
        end
    end

    cinv_cfg_sampler #(.LW(LW)) u_cfg (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .cfg_enable     (cfg_enable),
        .cfg_line_units (cfg_line_units),
        .eff            (eff),
        .err            (cfg_error)
    );

    cinv_hold_mask #(.AW(AW), .SHW(CINV_SHW)) u_mask (
        .shift (eff.shift),
        .mask  (hold_mask)
    );

    cinv_line_tracker #(.AW(AW), .SW(SW)) u_track (
        .clk      (clk),
        .rst      (rst),
        .owned    (bus_owned),
        .valid    (xfer_valid),
        .write    (xfer_write),
        .addr     (xfer_addr),
        .bytes    (xfer_bytes),
        .eff      (eff),
        .off_mask (~hold_mask),
        .fire     (fire)
    );

    assign inv_strobe = strobe_q;

    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        inv_strobe |-> $past(bus_owned && xfer_valid && xfer_write)); // R2

    AST_STROBE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        inv_strobe |-> $past(eff.en)); // R1

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ($countones(hold_mask ^ (hold_mask << 1)) == 1) && (hold_mask[1:0] == 2'b00)); // R7

endmodule

// File: tb/tb_cinv_strobe_gen.sv
`timescale 1ns/1ps
module tb_cinv_strobe_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [4:0]  cfg_line_units = '0;
    logic        bus_owned = 1'b0;
    logic        xfer_valid = 1'b0;
    logic        xfer_write = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic [2:0]  xfer_bytes = 3'd4;
    logic        inv_strobe;
    logic [31:0] hold_mask;
    logic        cfg_error;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    int          m_code;
    bit          m_en, m_fresh, m_owned;
    logic [31:0] m_last;

    always #2 clk = ~clk;

    cinv_strobe_gen dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_line_units(cfg_line_units),
        .bus_owned(bus_owned), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes), .inv_strobe(inv_strobe),
        .hold_mask(hold_mask), .cfg_error(cfg_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int line_bytes(input int code);
        if (code == 0) return 0;
        if ((code & (code - 1)) == 0 && code <= 16) return code * 4;
        return 0;
    endfunction

    function automatic logic [31:0] exp_mask(input int code);
        int lb = line_bytes(code);
        if (lb == 0) return ~32'h3;
        return ~(32'(lb) - 32'd1);
    endfunction

    task automatic grant(input int code, input bit en);
        bus_owned = 1'b1; cfg_line_units = 5'(code); cfg_enable = en; xfer_valid = 1'b0;
        @(negedge clk);
        m_code = code; m_en = en; m_fresh = 1; m_owned = 1;
    endtask

    task automatic release_bus();
        bus_owned = 1'b0; xfer_valid = 1'b0;
        @(negedge clk);
        m_fresh = 1; m_owned = 0;
    endtask

    task automatic beat(input logic [31:0] a, input int nb, input bit wr, input string req, output bit exp);
        int lb = line_bytes(m_code);
        logic [31:0] h, t;
        exp = 0;
        if (m_owned && wr && m_en) begin
            if (lb != 0) begin
                h = a / lb; t = (a + nb - 1) / lb;
                exp = m_fresh || (h != m_last) || (t != h);
                m_last = t;
            end else begin
                exp = m_fresh;
            end
            m_fresh = 0;
        end
        xfer_valid = 1'b1; xfer_write = wr; xfer_addr = a; xfer_bytes = 3'(nb);
        @(negedge clk);
        xfer_valid = 1'b0;
        chk(req, 32'(inv_strobe), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R10 strobe", 32'(inv_strobe), 0);
        chk("R10 error", 32'(cfg_error), 0);
        chk("R10 mask", hold_mask, ~32'h3);
    endtask

    task automatic t_legal();
        bit e;
        int codes[5] = '{1, 2, 4, 8, 16};
        foreach (codes[k]) begin
            int n = 0;
            grant(codes[k], 1);
            chk("R7 legal mask", hold_mask, exp_mask(codes[k]));
            for (int i = 0; i < 16; i++) begin
                beat(32'h1000 + 32'(4 * i), 4, 1, "R3 sequential", e);
                n += int'(inv_strobe);
            end
            chk("R3 strobe count", 32'(n), 32'(64 / (codes[k] * 4)));
            release_bus();
        end
    endtask

    task automatic t_infinite();
        bit e;
        int n = 0;
        grant(0, 1);
        chk("R7 infinite mask", hold_mask, ~32'h3);
        for (int i = 0; i < 10; i++) begin
            beat(32'h400 + 32'(20 * i), 4, 1, "R5 unbounded", e);
            n += int'(inv_strobe);
        end
        chk("R5 one strobe", 32'(n), 1);
        release_bus();
    endtask

    task automatic t_mixed();
        bit e;
        grant(2, 1);
        beat(32'h200, 4, 1, "R2 first write", e);
        beat(32'h208, 4, 0, "R2 read new line", e);
        beat(32'h204, 4, 1, "R2 same line after read", e);
        beat(32'h300, 4, 0, "R2 far read", e);
        beat(32'h208, 4, 1, "R2 write new line", e);
        beat(32'h20c, 4, 0, "R2 read", e);
        release_bus();
        beat(32'h800, 4, 1, "R2 write unowned", e);
        beat(32'h900, 4, 1, "R2 write unowned", e);
    endtask

    task automatic t_cross();
        bit e;
        grant(1, 1);
        beat(32'h40, 2, 1, "R3 first", e);
        beat(32'h42, 4, 1, "R3 spans two lines", e);
        beat(32'h46, 2, 1, "R3 same line as end", e);
        beat(32'h48, 4, 1, "R8 back to back a", e);
        beat(32'h4c, 4, 1, "R8 back to back b", e);
        @(negedge clk);
        chk("R8 single cycle pulse", 32'(inv_strobe), 0);
        release_bus();
    endtask

    task automatic t_regrant();
        bit e;
        for (int r = 0; r < 3; r++) begin
            grant(4, 1);
            beat(32'h84, 4, 1, "R4 first after grant", e);
            chk("R4 regrant strobe", 32'(inv_strobe), 1);
            beat(32'h88, 4, 1, "R4 same line", e);
            release_bus();
        end
    endtask

    task automatic t_disabled();
        bit e;
        int n = 0;
        grant(1, 0);
        for (int i = 0; i < 6; i++) begin
            beat(32'h600 + 32'(8 * i), 4, 1, "R1 disabled", e);
            n += int'(inv_strobe);
        end
        chk("R1 no strobes", 32'(n), 0);
        release_bus();
    endtask

    task automatic t_midchange();
        bit e;
        int n = 0;
        grant(16, 1);
        cfg_line_units = 5'd1; cfg_enable = 1'b0;
        for (int i = 0; i < 32; i++) begin
            beat(32'(4 * i), 4, 1, "R9 frozen config", e);
            n += int'(inv_strobe);
        end
        chk("R9 strobe count", 32'(n), 2);
        chk("R9 mask kept", hold_mask, ~32'h3f);
        release_bus();
    endtask

    task automatic t_reserved();
        bit e;
        int n = 0;
        grant(3, 1);
        chk("R6 error set", 32'(cfg_error), 1);
        chk("R7 reserved mask", hold_mask, ~32'h3);
        for (int i = 0; i < 8; i++) begin
            beat(32'h100 + 32'(4 * i), 4, 1, "R6 reserved as unbounded", e);
            n += int'(inv_strobe);
        end
        chk("R6 one strobe", 32'(n), 1);
        release_bus();
        grant(2, 1);
        chk("R6 error sticky", 32'(cfg_error), 1);
        beat(32'h10, 4, 1, "R6 legal after reserved", e);
        release_bus();
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_legal();
        t_infinite();
        t_mixed();
        t_cross();
        t_regrant();
        t_disabled();
        t_midchange();
        t_reserved();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule